// File: doc/BRIEF.md
# Trace Trigger Unit

This unit chooses the moment at which a trace snapshot is taken. It watches the processor's instruction completion stream and data access stream. It also watches strobes for taken branches and taken exceptions, and an asynchronous trigger pin from outside the chip. From these inputs it derives a set of internal events, selects which ones matter, and can require a number of occurrences before it acts. It can also require a two-step order, in which one event class must be seen before a second. When the programmed condition is met, the unit emits a single-cycle trigger pulse toward the capture logic.

Each pulse carries a flag. The flag is set when the trigger came from internal resources, so the boundary is exact: every instruction before the trigger point has completed and none after it has. The flag is clear when the external pin caused the trigger, because execution may have skidded past the real event. After a pulse the unit stays quiet until it is armed again. The configuration inputs are expected to be static while the unit is armed.

Top module: `trace_trigger`

## Requirements
- R1: After reset the unit is disarmed, and `trig_o` and `trig_precise_o` are 0. No event produces a pulse until `arm_i` has been high for a cycle.
- R2: Instruction comparator k raises internal event bit k (k = 0, 1) when `ic_vld_i` is 1, `ia_en_i[k]` is 1, and `ic_addr_i` equals `ia_cmp_i[k*32 +: 32]` exactly. A disabled comparator never raises its bit.
- R3: Data comparator k raises internal event bit 2+k when `dc_vld_i` is 1, `da_en_i[k]` is 1, and `dc_addr_i` equals `da_cmp_i[k*32 +: 32]` exactly. Nothing is raised while `dc_vld_i` is 0.
- R4: `br_taken_i` raises event bit 4 and `exc_taken_i` raises event bit 5. Either one is a trigger source once it is selected in `a_mask_i`.
- R5: A cycle in which any event selected by `a_mask_i` is present counts once, however many selected events are present. The first stage completes on count `term_cnt_i`, and a value of 0 behaves as 1.
- R6: When `seq_en_i` is 1, completing the first stage only advances to a second stage. The trigger fires on the first later cycle with an event selected by `b_mask_i`. A B event in or before the cycle that completes the first stage is not counted.
- R7: An internal trigger sets `trig_o` to 1 for exactly one cycle, the cycle after the clock edge at which the completing event was sampled, with `trig_precise_o` set to 1.
- R8: After a pulse, no further pulse occurs until `arm_i` is raised again. `arm_i` clears the occurrence count and the stage, and events in the cycle in which `arm_i` is high are ignored.
- R9: `ext_trig_i` passes through a two-flop synchronizer and a rising-edge detector. When `ext_sel_i` is 1 and the unit is armed, a rise sampled at edge k gives `trig_o` high after edge k+2 with `trig_precise_o` at 0. A level held high fires only once, and the pin is ignored when `ext_sel_i` is 0.
- R10: When an internal and an external trigger complete at the same edge, a single pulse is issued and it is marked precise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arms or re-arms the unit, clearing count and stage |
| ic_vld_i | input | 1 | Instruction completed this cycle |
| ic_addr_i | input | AW | Address of the completed instruction |
| dc_vld_i | input | 1 | Data access valid this cycle |
| dc_addr_i | input | AW | Data access address |
| br_taken_i | input | 1 | Branch taken strobe |
| exc_taken_i | input | 1 | Exception taken strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| ia_en_i | input | NIA | Instruction comparator enables |
| ia_cmp_i | input | NIA*AW | Instruction compare values, comparator k at bits k*AW |
| da_en_i | input | NDA | Data comparator enables |
| da_cmp_i | input | NDA*AW | Data compare values, comparator k at bits k*AW |
| a_mask_i | input | NIA+NDA+2 | Event selection for the first (counted) stage |
| b_mask_i | input | NIA+NDA+2 | Event selection for the second stage |
| seq_en_i | input | 1 | Enables the two-stage order |
| term_cnt_i | input | CW | Occurrences needed to complete the first stage |
| ext_sel_i | input | 1 | Accepts the external pin as a trigger source |
| trig_o | output | 1 | One-cycle trigger pulse |
| trig_precise_o | output | 1 | Pulse came from internal resources |

## Verification
A wrong occurrence count or a stale stage shows at the ports as a pulse that comes one event too early or too late. It can also show as a pulse that fires on a B event with no A event before it. Either symptom appears in the very cycle after the offending event. A broken synchronizer or edge detector moves the external pulse off its fixed two-edge delay, repeats it while the pin is held high, or clears the precise flag on a coincident internal trigger. The bench's per-cycle model catches each of these at the first divergent clock.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic {
    ST_A = 1'b0,
    ST_B = 1'b1
  } stage_e;
endpackage

// File: rtl/trig_addr_cmp.sv
module trig_addr_cmp #(
  parameter int AW = 32,
  parameter int N  = 2
) (
  input  logic          vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  en_i,
  input  logic [N*AW-1:0] cmp_i,
  output logic [N-1:0]  hit_o
);
  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign hit_o[k] = vld_i & en_i[k] & (addr_i == cmp_i[k*AW +: AW]);
  end
endmodule

// File: rtl/trig_ext_sync.sv
module trig_ext_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= ext_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign edge_o = s2_q & ~prev_q;

  // R9
  ext_edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NSRC = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic            armed_i,
  input  logic [NSRC-1:0] ev_i,
  input  logic [NSRC-1:0] a_mask_i,
  input  logic [NSRC-1:0] b_mask_i,
  input  logic            seq_en_i,
  input  logic [CW-1:0]   term_i,
  output logic            fire_o
);
  stage_e        stage_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   term_eff, cnt_next;
  logic          a_hit, b_hit, a_done, active;

  assign term_eff = (term_i == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, term_i};
  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign a_hit    = |(ev_i & a_mask_i);
  assign b_hit    = |(ev_i & b_mask_i);
  assign a_done   = a_hit & (cnt_next >= term_eff);
  assign active   = armed_i & ~arm_i;

  assign fire_o = active & (((stage_q == ST_A) & a_done & ~seq_en_i) |
                            ((stage_q == ST_B) & b_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_A;
      cnt_q   <= '0;
    end else if (arm_i) begin
      stage_q <= ST_A;
      cnt_q   <= '0;
    end else if (active && stage_q == ST_A && a_hit) begin
      if (a_done) begin
        cnt_q   <= '0;
        stage_q <= seq_en_i ? ST_B : ST_A;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

  // R6
  stage_b_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == ST_B) |-> (cnt_q == '0));
endmodule

// File: rtl/trace_trigger.sv
module trace_trigger #(
  parameter int AW  = 32,
  parameter int NIA = 2,
  parameter int NDA = 2,
  parameter int CW  = 16,
  localparam int NSRC = NIA + NDA + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              ic_vld_i,
  input  logic [AW-1:0]     ic_addr_i,
  input  logic              dc_vld_i,
  input  logic [AW-1:0]     dc_addr_i,
  input  logic              br_taken_i,
  input  logic              exc_taken_i,
  input  logic              ext_trig_i,
  input  logic [NIA-1:0]    ia_en_i,
  input  logic [NIA*AW-1:0] ia_cmp_i,
  input  logic [NDA-1:0]    da_en_i,
  input  logic [NDA*AW-1:0] da_cmp_i,
  input  logic [NSRC-1:0]   a_mask_i,
  input  logic [NSRC-1:0]   b_mask_i,
  input  logic              seq_en_i,
  input  logic [CW-1:0]     term_cnt_i,
  input  logic              ext_sel_i,
  output logic              trig_o,
  output logic              trig_precise_o
);
  logic [NIA-1:0]  ia_hit;
  logic [NDA-1:0]  da_hit;
  logic [NSRC-1:0] ev;
  logic            ext_edge, int_fire, ext_fire, fire;
  logic            armed_q, trig_q, prec_q;

  trig_addr_cmp #(.AW(AW), .N(NIA)) u_ia_cmp (
    .vld_i (ic_vld_i),
    .addr_i(ic_addr_i),
    .en_i  (ia_en_i),
    .cmp_i (ia_cmp_i),
    .hit_o (ia_hit)
  );

  trig_addr_cmp #(.AW(AW), .N(NDA)) u_da_cmp (
    .vld_i (dc_vld_i),
    .addr_i(dc_addr_i),
    .en_i  (da_en_i),
    .cmp_i (da_cmp_i),
    .hit_o (da_hit)
  );

  // event order: instr comparators, data comparators, branch, exception
  assign ev = {exc_taken_i, br_taken_i, da_hit, ia_hit};

  trig_ext_sync u_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ext_trig_i),
    .edge_o(ext_edge)
  );

  trig_seq #(.CW(CW), .NSRC(NSRC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .armed_i (armed_q),
    .ev_i    (ev),
    .a_mask_i(a_mask_i),
    .b_mask_i(b_mask_i),
    .seq_en_i(seq_en_i),
    .term_i  (term_cnt_i),
    .fire_o  (int_fire)
  );

  assign ext_fire = armed_q & ~arm_i & ext_sel_i & ext_edge;
  assign fire     = int_fire | ext_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      prec_q  <= 1'b0;
    end else begin
      if (arm_i)     armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
      trig_q <= fire;
      prec_q <= int_fire;
    end
  end

  assign trig_o         = trig_q;
  assign trig_precise_o = prec_q;

  // R7
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  // R7
  precise_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_precise_o |-> trig_o);

  // R8
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !armed_q);

  // R1
  armed_before_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_o) |-> $past(armed_q));
endmodule

// File: tb/trace_trigger_bench.sv
module trace_trigger_bench;
  localparam int AW = 32, NIA = 2, NDA = 2, CW = 16, NSRC = NIA + NDA + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, ic_vld = 0, dc_vld = 0, br = 0, exc = 0, ext = 0;
  logic [AW-1:0] ic_addr = '0, dc_addr = '0;
  logic [NIA-1:0] ia_en = '0;
  logic [NIA*AW-1:0] ia_cmp = '0;
  logic [NDA-1:0] da_en = '0;
  logic [NDA*AW-1:0] da_cmp = '0;
  logic [NSRC-1:0] a_mask = '0, b_mask = '0;
  logic seq_en = 0, ext_sel = 0;
  logic [CW-1:0] term = '0;
  logic trig, prec;

  always #5 clk = ~clk;

  trace_trigger u_trace_trigger (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm),
    .ic_vld_i(ic_vld), .ic_addr_i(ic_addr), .dc_vld_i(dc_vld), .dc_addr_i(dc_addr),
    .br_taken_i(br), .exc_taken_i(exc), .ext_trig_i(ext),
    .ia_en_i(ia_en), .ia_cmp_i(ia_cmp), .da_en_i(da_en), .da_cmp_i(da_cmp),
    .a_mask_i(a_mask), .b_mask_i(b_mask), .seq_en_i(seq_en), .term_cnt_i(term),
    .ext_sel_i(ext_sel), .trig_o(trig), .trig_precise_o(prec)
  );

  int checks = 0, fails = 0, pulses = 0, cycles = 0;
  bit last_prec = 0;
  string cur_req = "R1";

  // behavioural reference
  bit m_armed = 0, m_stb = 0, m_trig = 0, m_prec = 0;
  int m_cnt = 0;
  bit m_s1 = 0, m_s2 = 0, m_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_stb = 0; m_trig = 0; m_prec = 0; m_cnt = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      bit [NSRC-1:0] evs;
      bit edge_seen, ifire, efire;
      int teff;
      evs = '0;
      for (int k = 0; k < NIA; k++)
        if (ic_vld && ia_en[k] && ic_addr == ia_cmp[k*AW +: AW]) evs[k] = 1;
      for (int k = 0; k < NDA; k++)
        if (dc_vld && da_en[k] && dc_addr == da_cmp[k*AW +: AW]) evs[NIA+k] = 1;
      evs[NSRC-2] = br;
      evs[NSRC-1] = exc;
      edge_seen = m_s2 && !m_prev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ext;
      teff = (term == 0) ? 1 : int'(term);
      ifire = 0; efire = 0;
      if (arm) begin
        m_armed = 1; m_cnt = 0; m_stb = 0;
      end else if (m_armed) begin
        if (!m_stb && (evs & a_mask) != 0) begin
          if (m_cnt + 1 >= teff) begin
            m_cnt = 0;
            if (seq_en) m_stb = 1; else ifire = 1;
          end else m_cnt++;
        end else if (m_stb && (evs & b_mask) != 0) ifire = 1;
        efire = ext_sel && edge_seen;
        if (ifire || efire) m_armed = 0;
      end
      m_trig = ifire || efire;
      m_prec = ifire;
    end
  end

  task automatic check(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cur_req, trig, m_trig, "trig_o");
      check(cur_req, prec, m_prec, "trig_precise_o");
      if (trig === 1'b1) begin pulses++; last_prec = prec; end
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm_unit();
    arm = 1; tick(); arm = 0;
  endtask

  task automatic fetch(input logic [AW-1:0] a);
    ic_vld = 1; ic_addr = a; tick(); ic_vld = 0;
  endtask

  task automatic branch(input int n);
    for (int i = 0; i < n; i++) begin br = 1; tick(); br = 0; tick(); end
  endtask

  task automatic expect_pulses(input string req, input int exp);
    tick(4);
    checks++;
    if (pulses != exp) begin
      fails++;
      $display("FAIL %s pulse count: actual %0d expected %0d", req, pulses, exp);
    end
    pulses = 0;
  endtask

  task automatic expect_prec(input string req, input bit exp);
    checks++;
    if (last_prec != exp) begin
      fails++;
      $display("FAIL %s precise flag: actual %0d expected %0d", req, last_prec, exp);
    end
  endtask

  initial begin
    ia_cmp = {32'h0000_2000, 32'h0000_0100};
    da_cmp = {32'h0000_9000, 32'h0000_8000};
    tick(3);
    rst_n = 1;
    tick();
    // R1: reset state, no pulse before arming
    check("R1", trig, 1'b0, "reset trig_o");
    check("R1", prec, 1'b0, "reset trig_precise_o");
    ia_en = 2'b01; a_mask = 6'b000001;
    fetch(32'h100); branch(2);
    expect_pulses("R1", 0);

    // R2: instruction comparator 0, mismatch then match, R7 precise single pulse
    cur_req = "R2"; arm_unit();
    fetch(32'h104); tick(); fetch(32'h100);
    expect_pulses("R2", 1);
    expect_prec("R7", 1);
    // R8: no second pulse without re-arm
    cur_req = "R8"; fetch(32'h100); fetch(32'h100);
    expect_pulses("R8", 0);

    // R2: comparator 1 disabled then enabled
    cur_req = "R2"; a_mask = 6'b000010; arm_unit();
    fetch(32'h2000);
    expect_pulses("R2", 0);
    ia_en = 2'b11; fetch(32'h2000);
    expect_pulses("R2", 1);

    // R3: data comparator, invalid then valid
    cur_req = "R3"; a_mask = 6'b001000; da_en = 2'b11; arm_unit();
    dc_addr = 32'h9000; dc_vld = 0; tick(2);
    expect_pulses("R3", 0);
    dc_vld = 1; tick(); dc_vld = 0;
    expect_pulses("R3", 1);

    // R4: branch and exception sources
    cur_req = "R4"; a_mask = 6'b010000; arm_unit();
    exc = 1; tick(); exc = 0; tick();
    expect_pulses("R4", 0);
    branch(1);
    expect_pulses("R4", 1);
    a_mask = 6'b100000; arm_unit();
    exc = 1; tick(); exc = 0;
    expect_pulses("R4", 1);

    // R5: terminal count 3
    cur_req = "R5"; a_mask = 6'b010000; term = 3; arm_unit();
    branch(2);
    expect_pulses("R5", 0);
    branch(1);
    expect_pulses("R5", 1);
    // R5: two sources in one cycle count once
    a_mask = 6'b110000; term = 2; arm_unit();
    br = 1; exc = 1; tick(); br = 0; exc = 0;
    expect_pulses("R5", 0);
    branch(1);
    expect_pulses("R5", 1);

    // R6: sequencer A (instr 0) then B (branch)
    cur_req = "R6"; term = 1; seq_en = 1; a_mask = 6'b000001; b_mask = 6'b010000; arm_unit();
    branch(1);
    expect_pulses("R6", 0);
    ic_vld = 1; ic_addr = 32'h100; br = 1; tick(); ic_vld = 0; br = 0;
    expect_pulses("R6", 0);
    branch(1);
    expect_pulses("R6", 1);
    seq_en = 0; b_mask = '0;

    // R8: arm clears count, event in arm cycle ignored
    cur_req = "R8"; a_mask = 6'b010000; term = 3; arm_unit();
    branch(2);
    arm = 1; br = 1; tick(); arm = 0; br = 0; tick();
    branch(2);
    expect_pulses("R8", 0);
    branch(1);
    expect_pulses("R8", 1);

    // R9: external held high fires once, imprecise
    cur_req = "R9"; a_mask = '0; ext_sel = 1; arm_unit();
    ext = 1; tick(10);
    expect_pulses("R9", 1);
    expect_prec("R9", 0);
    ext = 0; tick(3); arm_unit();
    ext_sel = 0; ext = 1; tick(6); ext = 0; tick(3);
    expect_pulses("R9", 0);

    // R10: coincident internal and external
    cur_req = "R10"; ext_sel = 1; a_mask = 6'b010000; term = 1; arm_unit();
    ext = 1; tick(2); br = 1; tick(); br = 0;
    expect_pulses("R10", 1);
    expect_prec("R10", 1);
    ext = 0; tick(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule